// File: doc/BRIEF.md
# SPI Byte Shifter with Buffered Receive

This block is the data path of an 8-bit SPI port that can act as bus master or as slave. One shift register serves both directions: a CPU-side write puts the byte straight into it. There is no transmit holding stage. As the eight bits go out, the bits arriving from the far end fill the same register from the other side, so master and slave swap bytes. When the last bit lands, the received byte is copied into a separate receive buffer, and the transfer-complete flag rises in the same clock. CPU reads see only that buffer.

The hardware always shifts toward the MSB. Bit order is chosen by reversing the byte on its way into the shift register. The order in force at that write also decides whether the byte captured at the end of the transfer is reversed into the buffer. Changing the order input therefore only affects bytes written later.

A master starts a transfer as soon as its data register is written. It drives SCK at a quarter of the system clock, idle low. It changes its output on the falling SCK edge and samples its input on the rising edge. A slave follows the SCK edges it receives. A data write made while a transfer is running is dropped and raises the write-collision flag. Both flags clear when a status read is followed by a later data-register access. Reset clears only control and status state.

Top module: `spi_xfer_core`

## Requirements
- R1: Master and slave exchange bytes. After eight SCK pulses, each side's receive buffer holds the byte the other side wrote, when both use the same bit order.
- R2: In master mode SCK idles low. A transfer gives exactly 8 pulses, each 4 system clocks long and high for 2 of them.
- R3: A master-mode write that is accepted starts the transfer with no further command. SCK is first high in the third cycle after the accepting clock edge (the edge that accepts the write is edge 0, and SCK goes high at edge 2).
- R4: lsb_first_i = 1 at the write sends the byte LSB first, and lsb_first_i = 0 sends it MSB first. The received byte is reversed into the buffer when the order latched at that write is LSB first. A receiver using the opposite order from the sender therefore sees the sender's byte bit-reversed.
- R5: Changing lsb_first_i after a byte is written does not change how that byte is sent, and does not change how the byte received in that transfer is ordered.
- R6: rdata_o holds the last fully received byte. It does not change while a transfer is in progress. It takes the new byte in the same cycle in which done_o becomes 1. In master mode that is 30 clocks after the accepting edge.
- R7: A write while a transfer is in progress is discarded. The transfer completes with the original data, and wcol_o becomes 1.
- R8: done_o and wcol_o clear only on a data-register access (rd_i or wr_i) that comes after a stat_rd_i strobe. A data access with no status read before it leaves both flags set.
- R9: Reset sets done_o, wcol_o and sck_o to 0. It leaves rdata_o and the shift register contents unchanged. A slave that is not rewritten after reset sends the bits it last received.
- R10: In slave mode sck_o and mosi_o stay 0, and the shifted-out bits appear on miso_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1 = master, 0 = slave |
| lsb_first_i | input | 1 | Bit order for the next write: 1 = LSB first |
| wr_i | input | 1 | Data-register write strobe |
| rd_i | input | 1 | Data-register read strobe |
| stat_rd_i | input | 1 | Status-register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Receive buffer |
| done_o | output | 1 | Transfer-complete flag |
| wcol_o | output | 1 | Write-collision flag |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_i | input | 1 | Serial data in (slave) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| miso_o | output | 1 | Serial data out (slave) |

## Verification
Two copies are wired back to back, and bytes are swapped in random roles and orders. A design that reversed on the wrong side, or that took the order at capture time instead of at load time, would return mirrored bytes in the mixed-order and mid-transfer order-change cases. A collision write is injected in the middle of a transfer. A design that let that write through would corrupt the exchanged bytes or leave wcol_o low. The flag-clear sequence and a reset between transfers are also exercised: a design that cleared on a data read alone, or that reset the data path, would show set flags disappearing early or stale bytes replaced by zeros.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int unsigned SPI_DATA_W = 8;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_evt_t;
endpackage

// File: rtl/spi_sck_gen.sv
module spi_sck_gen import spi_xfer_pkg::*; #(
  parameter int unsigned DATA_W   = SPI_DATA_W,
  parameter int unsigned SCK_HALF = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  output logic     sck_o,
  output sck_evt_t evt_o,
  output logic     active_o
);
  localparam int unsigned PH_W  = $clog2(2 * SCK_HALF);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0]  PH_RISE  = PH_W'(SCK_HALF - 1);
  localparam logic [PH_W-1:0]  PH_FALL  = PH_W'(2 * SCK_HALF - 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  logic [PH_W-1:0]  ph_q;
  logic [CNT_W-1:0] bit_q;
  logic             active_q, sck_q;

  assign evt_o.rise = active_q && (ph_q == PH_RISE);
  assign evt_o.fall = active_q && (ph_q == PH_FALL);
  assign sck_o      = sck_q;
  assign active_o   = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      bit_q    <= '0;
      sck_q    <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      ph_q     <= '0;
      bit_q    <= '0;
      sck_q    <= 1'b0;
    end else if (active_q) begin
      ph_q <= (ph_q == PH_FALL) ? '0 : ph_q + 1'b1;
      if (evt_o.rise) sck_q <= 1'b1;
      if (evt_o.fall) begin
        sck_q <= 1'b0;
        bit_q <= bit_q + 1'b1;
        if (bit_q == BIT_LAST) active_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter import spi_xfer_pkg::*; #(
  parameter int unsigned DATA_W = SPI_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  sck_evt_t          evt_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              last_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rx_next_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic              sdo_q;
  logic [CNT_W-1:0]  cnt_q;

  assign rx_next_o = {sh_q[DATA_W-2:0], sdi_i};
  assign last_o    = evt_i.rise && (cnt_q == CNT_LAST);
  assign busy_o    = (cnt_q != '0);
  assign sdo_o     = sdo_q;

  // data path deliberately not reset
  always_ff @(posedge clk_i) begin
    if (load_i) begin
      sh_q  <= load_data_i;
      sdo_q <= load_data_i[DATA_W-1];
    end else begin
      if (evt_i.rise) sh_q  <= rx_next_o;
      if (evt_i.fall) sdo_q <= sh_q[DATA_W-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (load_i)     cnt_q <= '0;
    else if (evt_i.rise) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_flags.sv
module spi_flags import spi_xfer_pkg::*; #(
  parameter int unsigned DATA_W = SPI_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_evt_i,
  input  logic [DATA_W-1:0] rx_i,
  input  logic              wcol_evt_i,
  input  logic              stat_rd_i,
  input  logic              data_acc_i,
  output logic [DATA_W-1:0] rx_buf_o,
  output logic              done_o,
  output logic              wcol_o
);
  logic armed_q, done_q, wcol_q, clr;
  logic [DATA_W-1:0] rx_buf_q;

  assign clr      = data_acc_i && armed_q;
  assign done_o   = done_q;
  assign wcol_o   = wcol_q;
  assign rx_buf_o = rx_buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      wcol_q  <= 1'b0;
    end else begin
      if (stat_rd_i)       armed_q <= 1'b1;
      else if (data_acc_i) armed_q <= 1'b0;
      done_q <= done_evt_i | (done_q & ~clr);
      wcol_q <= wcol_evt_i | (wcol_q & ~clr);
    end
  end

  always_ff @(posedge clk_i) begin
    if (done_evt_i) rx_buf_q <= rx_i;
  end
endmodule

// File: rtl/spi_xfer_core.sv
module spi_xfer_core import spi_xfer_pkg::*; #(
  parameter int unsigned DATA_W   = SPI_DATA_W,
  parameter int unsigned SCK_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              lsb_first_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              stat_rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              wcol_o,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              miso_o
);
  function automatic logic [DATA_W-1:0] flip(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic order_q, sck_d_q;
  logic busy, gen_active, sh_busy, wr_ok, wcol_evt, start, done_evt, sdo, sdi, data_acc;
  sck_evt_t m_evt, s_evt, evt;
  logic [DATA_W-1:0] load_data, rx_next, rx_cap;

  assign busy      = master_i ? gen_active : sh_busy;
  assign wr_ok     = wr_i && !busy;
  assign wcol_evt  = wr_i && busy;
  assign start     = wr_ok && master_i;
  assign data_acc  = wr_i || rd_i;
  assign load_data = lsb_first_i ? flip(wdata_i) : wdata_i;
  assign rx_cap    = order_q ? flip(rx_next) : rx_next;

  // slave: sck_i assumed synchronous to clk_i
  assign s_evt.rise = !master_i && sck_i && !sck_d_q;
  assign s_evt.fall = !master_i && !sck_i && sck_d_q;
  assign evt        = master_i ? m_evt : s_evt;
  assign sdi        = master_i ? miso_i : mosi_i;
  assign mosi_o     = master_i && sdo;
  assign miso_o     = !master_i && sdo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_q <= 1'b0;
      sck_d_q <= 1'b0;
    end else begin
      sck_d_q <= sck_i;
      if (wr_ok) order_q <= lsb_first_i;
    end
  end

  spi_sck_gen #(.DATA_W(DATA_W), .SCK_HALF(SCK_HALF)) u_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .sck_o(sck_o), .evt_o(m_evt), .active_o(gen_active)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(wr_ok), .load_data_i(load_data),
    .evt_i(evt), .sdi_i(sdi), .sdo_o(sdo), .last_o(done_evt),
    .busy_o(sh_busy), .rx_next_o(rx_next)
  );

  spi_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_evt_i(done_evt), .rx_i(rx_cap),
    .wcol_evt_i(wcol_evt), .stat_rd_i(stat_rd_i), .data_acc_i(data_acc),
    .rx_buf_o(rdata_o), .done_o(done_o), .wcol_o(wcol_o)
  );
endmodule

// File: rtl/spi_xfer_core_chk.sv
module spi_xfer_core_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              wr_i,
  input logic              busy_i,
  input logic              done_evt_i,
  input logic              data_acc_i,
  input logic              sck_o,
  input logic              mosi_o,
  input logic              done_o,
  input logic              wcol_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] rx_cap_i
);
  // R7
  wcol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && busy_i |=> wcol_o);
  // R6
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_evt_i |=> $stable(rdata_o));
  // R6
  rx_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_evt_i |=> done_o && (rdata_o == $past(rx_cap_i)));
  // R2
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !sck_o);
  // R2
  sck_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |=> sck_o);
  // R8
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(data_acc_i));
  // R10
  slave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !mosi_o && !sck_o);
endmodule

bind spi_xfer_core spi_xfer_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .master_i(master_i), .wr_i(wr_i),
  .busy_i(busy), .done_evt_i(done_evt), .data_acc_i(data_acc),
  .sck_o(sck_o), .mosi_o(mosi_o), .done_o(done_o), .wcol_o(wcol_o),
  .rdata_o(rdata_o), .rx_cap_i(rx_cap)
);

// File: tb/spi_xfer_core_tb.sv
module spi_xfer_core_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic d_master = 1'b1, d_lsb = 1'b0, d_wr = 1'b0, d_rd = 1'b0, d_stat = 1'b0;
  logic p_master = 1'b0, p_lsb = 1'b0, p_wr = 1'b0, p_rd = 1'b0, p_stat = 1'b0;
  logic [7:0] d_wdata = '0, p_wdata = '0, d_rdata, p_rdata;
  logic d_done, d_wcol, p_done, p_wcol;
  logic d_sck, p_sck, d_mosi, p_mosi, d_miso, p_miso;

  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;

  spi_xfer_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(d_master), .lsb_first_i(d_lsb),
    .wr_i(d_wr), .rd_i(d_rd), .stat_rd_i(d_stat), .wdata_i(d_wdata),
    .rdata_o(d_rdata), .done_o(d_done), .wcol_o(d_wcol),
    .sck_i(p_sck), .sck_o(d_sck), .mosi_i(p_mosi), .mosi_o(d_mosi),
    .miso_i(p_miso), .miso_o(d_miso)
  );

  spi_xfer_core u_peer (
    .clk_i(clk), .rst_ni(rst_ni), .master_i(p_master), .lsb_first_i(p_lsb),
    .wr_i(p_wr), .rd_i(p_rd), .stat_rd_i(p_stat), .wdata_i(p_wdata),
    .rdata_o(p_rdata), .done_o(p_done), .wcol_o(p_wcol),
    .sck_i(d_sck), .sck_o(p_sck), .mosi_i(d_mosi), .mosi_o(p_mosi),
    .miso_i(d_miso), .miso_o(p_miso)
  );

  function automatic logic [7:0] rv(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction
  // bit sequence on the wire, MSB-first view
  function automatic logic [7:0] on_wire(input logic [7:0] b, input logic lsb);
    return lsb ? rv(b) : b;
  endfunction
  function automatic logic [7:0] rx_exp(input logic [7:0] w, input logic lsb);
    return lsb ? rv(w) : w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic d_write(input logic [7:0] b, input logic l);
    @(negedge clk); d_lsb = l; d_wdata = b; d_wr = 1'b1;
    @(negedge clk); d_wr = 1'b0;
  endtask
  task automatic p_write(input logic [7:0] b, input logic l);
    @(negedge clk); p_lsb = l; p_wdata = b; p_wr = 1'b1;
    @(negedge clk); p_wr = 1'b0;
  endtask

  task automatic clr_flags();
    @(negedge clk); d_stat = 1'b1; p_stat = 1'b1;
    @(negedge clk); d_stat = 1'b0; p_stat = 1'b0; d_rd = 1'b1; p_rd = 1'b1;
    @(negedge clk); d_rd = 1'b0; p_rd = 1'b0;
  endtask

  task automatic run_xfer(input logic dm, input logic [7:0] db, input logic dl,
                          input logic [7:0] pb, input logic pl, input int wcol_k, input int flip_k);
    logic [7:0] old_d, old_p, exp_d, exp_p, m_rd_at_done, exp_m;
    int rises, highs, first_hi, done_k;
    bit prev, quiet, mid_ok;
    @(negedge clk); d_master = dm; p_master = !dm;
    clr_flags();
    old_d = d_rdata; old_p = p_rdata;
    if (dm) begin p_write(pb, pl); d_write(db, dl); end
    else    begin d_write(db, dl); p_write(pb, pl); end
    rises = 0; highs = 0; first_hi = 0; done_k = 0; prev = 1'b0; quiet = 1'b1; mid_ok = 1'b1;
    m_rd_at_done = '0;
    for (int k = 1; k <= 40; k++) begin
      bit ms;
      ms = dm ? d_sck : p_sck;
      if (ms) begin highs++; if (first_hi == 0) first_hi = k; end
      if (ms && !prev) rises++;
      prev = ms;
      if (dm ? (p_sck || p_mosi) : (d_sck || d_mosi)) quiet = 1'b0;
      if (k == 20 && (d_rdata != old_d || p_rdata != old_p)) mid_ok = 1'b0;
      if (done_k == 0 && (dm ? d_done : p_done)) begin
        done_k = k;
        m_rd_at_done = dm ? d_rdata : p_rdata;
      end
      d_wr = (k == wcol_k); p_wr = (k == wcol_k);
      if (k == wcol_k) begin d_wdata = ~db; p_wdata = ~pb; end
      if (k == flip_k) begin d_lsb = !d_lsb; p_lsb = !p_lsb; end
      @(negedge clk);
    end
    d_wr = 1'b0; p_wr = 1'b0;
    exp_d = rx_exp(on_wire(pb, pl), dl);
    exp_p = rx_exp(on_wire(db, dl), pl);
    exp_m = dm ? exp_d : exp_p;
    chk(d_rdata == exp_d, "R1 R4 R5 dut rx", d_rdata, exp_d);
    chk(p_rdata == exp_p, "R1 R4 R5 peer rx", p_rdata, exp_p);
    chk(d_done && p_done, "R6 done set", {d_done, p_done}, 2'b11);
    chk(mid_ok, "R6 buffer held mid transfer", mid_ok, 1);
    chk(done_k == 31, "R6 done timing", done_k, 31);
    chk(m_rd_at_done == exp_m, "R6 buffer with done", m_rd_at_done, exp_m);
    chk(rises == 8 && highs == 16, "R2 sck pulses", {rises[15:0], highs[15:0]}, {16'd8, 16'd16});
    chk(first_hi == 3, "R3 first sck high", first_hi, 3);
    chk(!prev, "R2 sck idle low", prev, 0);
    chk(quiet, "R10 slave sck/mosi quiet", quiet, 1);
    if (wcol_k != 0) chk(d_wcol && p_wcol, "R7 wcol set", {d_wcol, p_wcol}, 2'b11);
    else             chk(!d_wcol && !p_wcol, "R7 wcol clear", {d_wcol, p_wcol}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b, c, keep_d, keep_p, e;
    logic dm, dl, pl;
    int unsigned seed;
    seed = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    chk(!d_done && !d_wcol && !d_sck, "R9 reset state", {d_done, d_wcol, d_sck}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // directed
    run_xfer(1'b1, 8'hC3, 1'b0, 8'h5A, 1'b0, 0, 0);
    run_xfer(1'b1, 8'h81, 1'b1, 8'h37, 1'b1, 0, 0);
    run_xfer(1'b1, 8'h01, 1'b1, 8'hF0, 1'b0, 0, 0);   // mixed order, R4
    run_xfer(1'b0, 8'h96, 1'b0, 8'h2D, 1'b1, 0, 0);   // dut as slave, R10
    run_xfer(1'b1, 8'hE1, 1'b0, 8'h0F, 1'b1, 0, 5);   // order flip mid transfer, R5
    run_xfer(1'b0, 8'h3C, 1'b1, 8'hA7, 1'b0, 10, 0);  // collision, R7

    // R8: flags clear only on data access after status read
    @(negedge clk); d_rd = 1'b1;
    @(negedge clk); d_rd = 1'b0;
    chk(d_done && d_wcol, "R8 rd without stat keeps flags", {d_done, d_wcol}, 2'b11);
    d_stat = 1'b1;
    @(negedge clk); d_stat = 1'b0;
    chk(d_done && d_wcol, "R8 stat alone keeps flags", {d_done, d_wcol}, 2'b11);
    d_rd = 1'b1;
    @(negedge clk); d_rd = 1'b0;
    chk(!d_done && !d_wcol, "R8 stat then rd clears", {d_done, d_wcol}, 2'b00);

    // random
    for (int n = 0; n < 16; n++) begin
      a = 8'($urandom); b = 8'($urandom);
      dm = 1'($urandom); dl = 1'($urandom); pl = 1'($urandom);
      run_xfer(dm, a, dl, b, pl, 0, 0);
    end

    // R9: reset keeps data path
    a = 8'h6B; b = 8'hD4; c = 8'h1E;
    run_xfer(1'b1, a, 1'b1, b, 1'b0, 0, 0);
    keep_d = d_rdata; keep_p = p_rdata;
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(!d_done && !d_wcol && !p_done && !d_sck, "R9 flags reset",
        {d_done, d_wcol, p_done, d_sck}, 0);
    chk(d_rdata == keep_d && p_rdata == keep_p, "R9 rx buffers kept",
        {d_rdata, p_rdata}, {keep_d, keep_p});
    rst_ni = 1'b1;
    @(negedge clk);
    d_write(c, 1'b0);
    repeat (40) @(negedge clk);
    e = rx_exp(on_wire(a, 1'b1), 1'b0);
    chk(d_rdata == e, "R9 slave shift reg kept", d_rdata, e);
    e = on_wire(c, 1'b0);
    chk(p_rdata == e, "R9 peer rx after reset", p_rdata, e);

    fin = 1'b1;
    summary();
    $finish;
  end
endmodule